// File: doc/BRIEF.md
# Jacobi Relaxation Solver for Small Dense Systems

This block computes the correction vector dx of a nine-unknown Newton step by solving J·dx = −f with point-Jacobi relaxation in signed Q16.16 fixed point. The host fills the 9×9 coefficient matrix and the residual vector through a single indexed write port, then pulses `start`. The block runs sweeps. Every unknown of a sweep is built only from the vector that the previous sweep left behind. The new vector is committed as one unit when the sweep ends.

The run stops in one of three ways. All changes in a sweep can fall below a programmable tolerance, the sweep cap can be reached, or a zero diagonal coefficient can be found. The block then raises a one-cycle `done`, reports the number of committed sweeps and shows the solution on an indexed read port. The committed vector is kept between runs, so each run starts from the last answer. After reset that starting vector is all zeros.

Top module: `jr_solver`

## Requirements
- R1: Write address a < 81 loads matrix element J[a/9][a%9] (row-major), address 81+i loads residual f_i, and higher addresses are dropped; a write happens on any clock edge with `wr_en` high.
- R2: After reset, `busy`, `done`, `err_zero_diag`, `converged` and `sweeps` are 0, and the read port returns 0 for every unknown.
- R3: Each new value is x_i = (−f_i − Σ_{j≠i} J_ij·x_j) / J_ii in Q16.16. Each product is the full 64-bit product shifted right by 16 with floor rounding. The quotient is sign·floor(|s|·2^16 / |J_ii|).
- R4: Every update within a sweep uses only the vector committed at the end of the previous sweep, and all nine new values are committed together at the end of the sweep.
- R5: A run commits at most 11 sweeps. With tolerance 0 it always commits exactly 11, and `converged` stays 0.
- R6: When every |x_new − x_old| of a sweep is strictly below the unsigned tolerance `tol`, the run ends after committing that sweep, with `converged` = 1 and `sweeps` equal to the number of sweeps committed.
- R7: Each run starts from the vector that the previous run committed; the first run after reset starts from zero.
- R8: A zero diagonal coefficient found when a row is reached ends the run with `err_zero_diag` = 1 and `done`. The partial sweep is discarded, the committed vector is unchanged, and `sweeps` counts only the completed sweeps.
- R9: The row sum saturates to [−2^31, 2^31−1] before division, and the quotient saturates to the same range.
- R10: `busy` is high from the cycle after an accepted start until the end of the `done` cycle. `done` is high for exactly one cycle.
- R11: A `start` pulse while `busy` is high has no effect on the run or its results.
- R12: `rd_data` shows committed unknown `rd_idx` combinationally, and shows 0 for `rd_idx` ≥ 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Load strobe for matrix or residual |
| wr_addr | input | 7 | Load address (matrix row-major, then residual) |
| wr_data | input | 32 | Q16.16 value to load |
| start | input | 1 | Begin a run (ignored while busy) |
| tol | input | 32 | Unsigned early-exit tolerance, Q16.16; 0 disables early exit |
| rd_idx | input | 4 | Unknown to read |
| rd_data | output | 32 | Committed value of the selected unknown |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| err_zero_diag | output | 1 | Last run ended on a zero diagonal |
| converged | output | 1 | Last run ended by the tolerance test |
| sweeps | output | 4 | Sweeps committed in the last run |

## Verification
Assertions check the following on every cycle. The committed vector moves only at a sweep boundary. `done` never lasts two cycles. A zero-diagonal error always appears together with `done`. The sweep count never passes the cap. The divider never starts on a zero divisor, and the row accumulator is never cleared and fed in the same cycle. Only the bench scenarios can show the numerical results: a bit-exact model of the Jacobi arithmetic is compared against the read port across a cold start, a warm start, an early exit, saturating rows, an aborted run and a start pulse during a run.

// File: rtl/jr_pkg.sv
package jr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROW,
    ST_MAC,
    ST_DIVGO,
    ST_DIVWAIT,
    ST_SWEEP,
    ST_FINISH
  } jr_state_e;
endpackage

// File: rtl/jr_accum.sv
module jr_accum #(
  parameter int W    = 32,
  parameter int FRAC = 16,
  parameter int N    = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] init,
  input  logic [W-1:0] coef,
  input  logic [W-1:0] xval,
  output logic [W-1:0] sum_sat
);
  localparam int PW    = 2 * W;
  localparam int ACC_W = PW + $clog2(N) + 1;

  logic signed [PW-1:0]    prod;
  logic signed [PW-1:0]    term;
  logic signed [ACC_W-1:0] acc_q, acc_d;
  logic                    ovf;

  assign prod = $signed(coef) * $signed(xval);
  assign term = prod >>> FRAC;

  always_comb begin
    acc_d = acc_q;
    if (clr) begin
      acc_d = '0 - ACC_W'($signed(init));
    end else if (en) begin
      acc_d = acc_q - ACC_W'(term);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  // row sum clamps to the W-bit signed range before it reaches the divider
  assign ovf = !((&acc_q[ACC_W-1:W-1]) || !(|acc_q[ACC_W-1:W-1]));
  assign sum_sat = ovf ? (acc_q[ACC_W-1] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}})
                       : acc_q[W-1:0];

  assert_clr_en_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n) !(clr && en));
endmodule

// File: rtl/jr_div.sv
module jr_div #(
  parameter int W    = 32,
  parameter int FRAC = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         done,
  output logic [W-1:0] quot
);
  localparam int DW = W + FRAC;
  localparam int CW = $clog2(DW + 1);

  logic [W-1:0]  rem_q, rem_d, den_q, den_d;
  logic [DW-1:0] q_q, q_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          run_q, run_d, neg_q, neg_d, done_q, done_d;
  logic [W:0]    trial;
  logic          ge;
  logic [W-1:0]  mag_n, mag_d;
  logic          big_neg, big_pos;

  assign mag_n = dividend[W-1] ? (~dividend + 1'b1) : dividend;
  assign mag_d = divisor[W-1]  ? (~divisor + 1'b1)  : divisor;
  assign trial = {rem_q, q_q[DW-1]};
  assign ge    = trial >= {1'b0, den_q};

  always_comb begin
    rem_d  = rem_q;
    den_d  = den_q;
    q_d    = q_q;
    cnt_d  = cnt_q;
    run_d  = run_q;
    neg_d  = neg_q;
    done_d = 1'b0;
    if (go) begin
      rem_d = '0;
      den_d = mag_d;
      q_d   = {mag_n, {FRAC{1'b0}}};
      cnt_d = CW'(DW);
      run_d = 1'b1;
      neg_d = dividend[W-1] ^ divisor[W-1];
    end else if (run_q) begin
      rem_d = ge ? W'(trial - {1'b0, den_q}) : trial[W-1:0];
      q_d   = {q_q[DW-2:0], ge};
      cnt_d = cnt_q - 1'b1;
      if (cnt_q == CW'(1)) begin
        run_d  = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      den_q  <= '0;
      q_q    <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      neg_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      rem_q  <= rem_d;
      den_q  <= den_d;
      q_q    <= q_d;
      cnt_q  <= cnt_d;
      run_q  <= run_d;
      neg_q  <= neg_d;
      done_q <= done_d;
    end
  end

  // magnitude clamp: negative side reaches 2^(W-1), positive side 2^(W-1)-1
  assign big_neg = (|q_q[DW-1:W]) || (q_q[W-1] && (|q_q[W-2:0]));
  assign big_pos = |q_q[DW-1:W-1];
  always_comb begin
    if (neg_q) quot = big_neg ? {1'b1, {(W-1){1'b0}}} : (~q_q[W-1:0] + 1'b1);
    else       quot = big_pos ? {1'b0, {(W-1){1'b1}}} : q_q[W-1:0];
  end
  assign done = done_q;

  assert_div_nonzero_R8: assert property (@(posedge clk) disable iff (!rst_n) go |-> (divisor != '0));
  assert_div_idle_on_go_R3: assert property (@(posedge clk) disable iff (!rst_n) go |-> !run_q);
  assert_div_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
endmodule

// File: rtl/jr_conv.sv
module jr_conv #(
  parameter int N = 9,
  parameter int W = 32
) (
  input  logic [W-1:0] x_new [N],
  input  logic [W-1:0] x_old [N],
  input  logic [W-1:0] tol,
  output logic         all_close
);
  logic [N-1:0] close;

  for (genvar g = 0; g < N; g++) begin : g_lane
    logic signed [W:0] diff;
    logic [W:0]        mag;
    assign diff     = $signed({x_new[g][W-1], x_new[g]}) - $signed({x_old[g][W-1], x_old[g]});
    assign mag      = diff[W] ? (~diff + 1'b1) : diff;
    assign close[g] = mag < {1'b0, tol};
  end

  assign all_close = &close;
endmodule

// File: rtl/jr_solver.sv
module jr_solver
  import jr_pkg::*;
#(
  parameter int N          = 9,
  parameter int W          = 32,
  parameter int FRAC       = 16,
  parameter int MAX_SWEEPS = 11
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic [$clog2(N*N+N)-1:0]          wr_addr,
  input  logic [W-1:0]                      wr_data,
  input  logic                              start,
  input  logic [W-1:0]                      tol,
  input  logic [$clog2(N)-1:0]              rd_idx,
  output logic [W-1:0]                      rd_data,
  output logic                              busy,
  output logic                              done,
  output logic                              err_zero_diag,
  output logic                              converged,
  output logic [$clog2(MAX_SWEEPS+1)-1:0]   sweeps
);
  localparam int NN = N * N;
  localparam int AW = $clog2(NN + N);
  localparam int IW = $clog2(N);
  localparam int SW = $clog2(MAX_SWEEPS + 1);

  logic [1:0] rst_sync;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_sync_n = rst_sync[1];

  logic [W-1:0] coef_q  [NN];
  logic [W-1:0] resid_q [N];
  logic [W-1:0] x_old_q [N];
  logic [W-1:0] x_new_q [N];

  for (genvar g = 0; g < NN; g++) begin : g_coef
    always_ff @(posedge clk) begin
      if (wr_en && (wr_addr == AW'(g))) coef_q[g] <= wr_data;
    end
  end
  for (genvar g = 0; g < N; g++) begin : g_resid
    always_ff @(posedge clk) begin
      if (wr_en && (wr_addr == AW'(NN + g))) resid_q[g] <= wr_data;
    end
  end

  jr_state_e     st_q, st_d;
  logic [IW-1:0] row_q, row_d, col_q, col_d;
  logic [SW-1:0] sw_q, sw_d;
  logic          err_q, err_d, conv_q, conv_d;
  logic          acc_clr, acc_en, div_go, xnew_we, xold_we;
  logic [AW-1:0] cidx, didx;
  logic [W-1:0]  diag, mac_coef, row_sum, div_q;
  logic          div_done, all_close;

  assign cidx     = AW'(row_q) * AW'(N) + AW'(col_q);
  assign didx     = AW'(row_q) * AW'(N + 1);
  assign diag     = coef_q[didx];
  assign mac_coef = (col_q == row_q) ? '0 : coef_q[cidx];

  jr_accum #(.W(W), .FRAC(FRAC), .N(N)) u_accum (
    .clk(clk), .rst_n(rst_sync_n), .clr(acc_clr), .en(acc_en),
    .init(resid_q[row_q]), .coef(mac_coef), .xval(x_old_q[col_q]), .sum_sat(row_sum)
  );

  jr_div #(.W(W), .FRAC(FRAC)) u_div (
    .clk(clk), .rst_n(rst_sync_n), .go(div_go), .dividend(row_sum), .divisor(diag),
    .done(div_done), .quot(div_q)
  );

  jr_conv #(.N(N), .W(W)) u_conv (
    .x_new(x_new_q), .x_old(x_old_q), .tol(tol), .all_close(all_close)
  );

  always_comb begin
    st_d    = st_q;
    row_d   = row_q;
    col_d   = col_q;
    sw_d    = sw_q;
    err_d   = err_q;
    conv_d  = conv_q;
    acc_clr = 1'b0;
    acc_en  = 1'b0;
    div_go  = 1'b0;
    xnew_we = 1'b0;
    xold_we = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d   = ST_ROW;
          row_d  = '0;
          sw_d   = '0;
          err_d  = 1'b0;
          conv_d = 1'b0;
        end
      end
      ST_ROW: begin
        if (diag == '0) begin
          err_d = 1'b1;
          st_d  = ST_FINISH;
        end else begin
          acc_clr = 1'b1;
          col_d   = '0;
          st_d    = ST_MAC;
        end
      end
      ST_MAC: begin
        acc_en = 1'b1;
        if (col_q == IW'(N - 1)) st_d = ST_DIVGO;
        else                     col_d = col_q + 1'b1;
      end
      ST_DIVGO: begin
        div_go = 1'b1;
        st_d   = ST_DIVWAIT;
      end
      ST_DIVWAIT: begin
        if (div_done) begin
          xnew_we = 1'b1;
          if (row_q == IW'(N - 1)) begin
            st_d = ST_SWEEP;
          end else begin
            row_d = row_q + 1'b1;
            st_d  = ST_ROW;
          end
        end
      end
      ST_SWEEP: begin
        xold_we = 1'b1;
        sw_d    = sw_q + 1'b1;
        if (all_close) begin
          conv_d = 1'b1;
          st_d   = ST_FINISH;
        end else if (sw_q == SW'(MAX_SWEEPS - 1)) begin
          st_d = ST_FINISH;
        end else begin
          row_d = '0;
          st_d  = ST_ROW;
        end
      end
      ST_FINISH: st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      st_q   <= ST_IDLE;
      row_q  <= '0;
      col_q  <= '0;
      sw_q   <= '0;
      err_q  <= 1'b0;
      conv_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      row_q  <= row_d;
      col_q  <= col_d;
      sw_q   <= sw_d;
      err_q  <= err_d;
      conv_q <= conv_d;
    end
  end

  always_ff @(posedge clk) begin
    if (xnew_we) x_new_q[row_q] <= div_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      for (int i = 0; i < N; i++) x_old_q[i] <= '0;
    end else if (xold_we) begin
      for (int i = 0; i < N; i++) x_old_q[i] <= x_new_q[i];
    end
  end

  assign rd_data       = (32'(rd_idx) < N) ? x_old_q[rd_idx] : '0;
  assign busy          = (st_q != ST_IDLE);
  assign done          = (st_q == ST_FINISH);
  assign err_zero_diag = err_q;
  assign converged     = conv_q;
  assign sweeps        = sw_q;

  logic [N*W-1:0] x_old_flat;
  for (genvar g = 0; g < N; g++) begin : g_flat
    assign x_old_flat[g*W +: W] = x_old_q[g];
  end

  assert_xold_only_at_sweep_end_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (st_q != ST_SWEEP) |=> $stable(x_old_flat));
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done |=> !done);
  assert_err_ends_run_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(err_zero_diag) |-> done);
  assert_sweep_cap_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done |-> (sweeps <= SW'(MAX_SWEEPS)));
endmodule

// File: tb/jr_solver_bench.sv
`timescale 1ns/1ps
module jr_solver_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [6:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        start = 1'b0;
  logic [31:0] tol = '0;
  logic [3:0]  rd_idx = '0;
  logic [31:0] rd_data;
  logic        busy, done, err_zero_diag, converged;
  logic [3:0]  sweeps;

  int errors = 0;
  int checks = 0;

  int Jm [9][9];
  int Fm [9];
  int Xm [9];

  always #2 clk = ~clk;

  jr_solver u_jr_solver (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .start(start), .tol(tol), .rd_idx(rd_idx), .rd_data(rd_data), .busy(busy),
    .done(done), .err_zero_diag(err_zero_diag), .converged(converged), .sweeps(sweeps)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint sat32(input longint v);
    if (v > 64'sd2147483647) return 64'sd2147483647;
    if (v < -64'sd2147483648) return -64'sd2147483648;
    return v;
  endfunction

  task automatic model_solve(input longint tl, output int sw, output bit conv, output bit err);
    int nx [9];
    sw = 0; conv = 0; err = 0;
    for (int s = 0; s < 11; s++) begin
      for (int i = 0; i < 9; i++) begin
        longint acc, mag, d, q;
        bit neg;
        if (Jm[i][i] == 0) begin err = 1; return; end
        acc = -longint'(Fm[i]);
        for (int j = 0; j < 9; j++)
          if (j != i) acc -= (longint'(Jm[i][j]) * longint'(Xm[j])) >>> 16;
        acc = sat32(acc);
        mag = (acc < 0) ? -acc : acc;
        d = (Jm[i][i] < 0) ? -longint'(Jm[i][i]) : longint'(Jm[i][i]);
        q = (mag * 65536) / d;
        neg = (acc < 0) ^ (Jm[i][i] < 0);
        nx[i] = int'(neg ? sat32(-q) : sat32(q));
      end
      conv = 1;
      for (int i = 0; i < 9; i++) begin
        longint df = longint'(nx[i]) - longint'(Xm[i]);
        if (df < 0) df = -df;
        if (!(df < tl)) conv = 0;
      end
      for (int i = 0; i < 9; i++) Xm[i] = nx[i];
      sw = s + 1;
      if (conv) return;
    end
  endtask

  task automatic load_all();
    for (int a = 0; a < 90; a++) begin
      @(negedge clk);
      wr_en = 1'b1;
      wr_addr = 7'(a);
      wr_data = (a < 81) ? Jm[a / 9][a % 9] : Fm[a - 81];
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic check_vector(input string req);
    for (int i = 0; i < 9; i++) begin
      @(negedge clk);
      rd_idx = 4'(i);
      #1;
      chk(req, longint'($signed(rd_data)), longint'(Xm[i]));
    end
  endtask

  // pulses start, optionally pulses it again mid-run, then checks the end-of-run handshake
  task automatic run_and_check(input string req, input longint tl, input bit restart);
    int msw, cyc;
    bit mconv, merr;
    model_solve(tl, msw, mconv, merr);
    tol = 32'(tl);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R10 busy after start", busy, 1);
    cyc = 0;
    while (!done && cyc < 20000) begin
      start = (restart && (cyc == 40 || cyc == 300)) ? 1'b1 : 1'b0;
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    chk("R10 done reached", done, 1);
    chk({req, " sweeps"}, sweeps, msw);
    chk({req, " converged"}, converged, mconv);
    chk({req, " err"}, err_zero_diag, merr);
    @(negedge clk);
    chk("R10 done one cycle", done, 0);
    chk("R10 idle after done", busy, 0);
    check_vector(req);
  endtask

  task automatic t_reset();
    chk("R2 busy", busy, 0);
    chk("R2 done", done, 0);
    chk("R2 err", err_zero_diag, 0);
    chk("R2 converged", converged, 0);
    chk("R2 sweeps", sweeps, 0);
    for (int i = 0; i < 9; i++) Xm[i] = 0;
    check_vector("R2 reset vector");
  endtask

  task automatic t_cold_capped();
    for (int i = 0; i < 9; i++) begin
      for (int j = 0; j < 9; j++)
        Jm[i][j] = (i == j) ? (8 + i) * 65536 : (((i * 3 + j * 5) % 7) - 3) * 16384;
      Fm[i] = (((i * 7) % 11) - 5) * 65536 + i * 1234;
    end
    load_all();  // R1 address map
    run_and_check("R3 R4 R5 R7 cold capped", 0, 1'b0);
    chk("R5 exactly eleven", sweeps, 11);
  endtask

  task automatic t_warm_early_exit();
    run_and_check("R6 R7 warm early exit", 64, 1'b0);
    chk("R6 converged", converged, 1);
  endtask

  task automatic t_negative_restart();
    for (int i = 0; i < 9; i++) begin
      for (int j = 0; j < 9; j++)
        Jm[i][j] = (i == j) ? -(6 + i) * 65536 : (((i * 5 + j * 2) % 9) - 4) * 9000;
      Fm[i] = (i - 4) * 100000 + 777;
    end
    load_all();
    run_and_check("R11 R3 restart ignored", 0, 1'b1);
  endtask

  task automatic t_saturation();
    for (int i = 0; i < 9; i++) begin
      for (int j = 0; j < 9; j++) Jm[i][j] = (i == j) ? 65536 : 0;
      Fm[i] = i * 65536;
    end
    Jm[0][0] = 1; Fm[0] = -65536;
    Jm[1][1] = 1; Fm[1] = 65536;
    Fm[2] = 32'h80000000;
    load_all();
    run_and_check("R9 saturation", 1, 1'b0);
    @(negedge clk); rd_idx = 4'd0; #1;
    chk("R9 quotient high clamp", rd_data, 32'h7FFFFFFF);
    @(negedge clk); rd_idx = 4'd1; #1;
    chk("R9 quotient low clamp", rd_data, 32'h80000000);
    @(negedge clk); rd_idx = 4'd2; #1;
    chk("R9 sum clamp", rd_data, 32'h7FFFFFFF);
  endtask

  task automatic t_zero_diag();
    for (int i = 0; i < 9; i++) begin
      for (int j = 0; j < 9; j++) Jm[i][j] = (i == j) ? 4 * 65536 : 8192;
      Fm[i] = 3000 * i;
    end
    Jm[3][3] = 0;
    load_all();
    run_and_check("R8 zero diagonal", 0, 1'b0);
    chk("R8 err set", err_zero_diag, 1);
    chk("R8 no sweep", sweeps, 0);
  endtask

  task automatic t_read_range();
    for (int i = 9; i < 16; i++) begin
      @(negedge clk);
      rd_idx = 4'(i);
      #1;
      chk("R12 out of range", rd_data, 0);
    end
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_cold_capped();
    t_warm_early_exit();
    t_negative_restart();
    t_saturation();
    t_zero_diag();
    t_read_range();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule